// File: doc/BRIEF.md
# Exclusive Two-Level Cache Swap Controller

This block manages the tag, valid and dirty state of a small first-level cache and a larger second-level cache that never hold the same line at once. Requests come in one at a time on a valid/ready port, each carrying an address and a read or write flag. A first-level hit finishes at once. A second-level hit moves the requested line up into the first level, and the first-level victim moves down into the second level. A miss at both levels fetches the line from a backing memory into the first level. When the displaced second-level line is dirty, it is written back first. The block keeps only the state of the two levels. It moves no line data, so the memory port carries line addresses and a write-back flag only.

A separate invalidate input removes a line from whichever level holds it. Inclusion is not enforced, so the block probes both levels for every invalidate. Each finished transaction gives a one-cycle response that says where the line was found: first level, second level, memory, or nowhere for an invalidate. At the default settings the first level is 2-way with 8 sets and the second level is 4-way with 32 sets. Both levels use 16-byte lines and 32-bit addresses.

Top module: `excl_l2_swap_ctrl`

## Requirements
- R1: A line address is valid in at most one level at a time. After a second-level hit the line answers from the first level and is no longer in the second, so a repeated invalidate of any line reports level 0.
- R2: A request that hits in the first level responds with rsp_level 1 (encoding: 0 none, 1 first level, 2 second level, 3 memory) and makes no memory transaction.
- R3: A first-level miss that hits in the second level responds with rsp_level 2 and reads nothing from memory. The line moves into the first-level victim way. The first-level victim is demoted into the second-level set given by its own address.
- R4: A miss at both levels issues exactly one memory read (mem_we 0) at the line-aligned address (low 4 bits zero) and responds with rsp_level 3.
- R5: When the second-level line displaced by a demotion is dirty, the block issues one write-back (mem_we 1) at that line's aligned address before it completes. A clean displaced line is dropped without any memory traffic.
- R6: Victim choice in both levels takes the lowest-numbered invalid way first. Otherwise it takes the least recently used way. Hits, fills and demotions count as use; invalidation and removal by a swap do not.
- R7: A write marks its line dirty. Dirtiness moves with the line in both directions between the levels.
- R8: An invalidate probes both levels, clears the line where found and responds with rsp_inv 1 and rsp_level 1, 2 or 0. It never writes back. When inv_valid and req_valid are both high in an idle cycle, the invalidate is taken and the request is not.
- R9: req_ready is high only while idle. rsp_valid is a one-cycle pulse. mem_req stays high, with mem_addr and mem_we stable, until mem_ack is seen.
- R10: Reset (synchronous, active-low) empties both levels. After reset req_ready is 1, rsp_valid is 0 and mem_req is 0, and the first access to any line misses to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller idle and able to take a request or invalidate |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| inv_valid | input | 1 | Invalidate request present (has priority over req_valid) |
| inv_addr | input | 32 | Byte address of the line to remove |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_level | output | 2 | Where the line was found: 0 none, 1 first level, 2 second level, 3 memory |
| rsp_inv | output | 1 | The response belongs to an invalidate |
| mem_req | output | 1 | Backing memory transaction pending |
| mem_we | output | 1 | 1 for a write-back, 0 for a line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_ack | input | 1 | Memory accepts the pending transaction this cycle |

## Verification
A wrong tag, valid bit or age shows up at the ports on the next access to the affected set. The response then reports the wrong level, or the memory port shows a read that should not happen or misses one that should. A lost or wrong dirty bit stays hidden until that line is pushed out of the second level, which can take several more conflicting accesses. At that point a write-back appears where none is due, or fails to appear. A line held at both levels is exposed by an invalidate that reports a level and then, on a second invalidate, reports a level again instead of 0. The bench therefore keeps a reference copy of both levels, including ages and dirty bits, and compares every response and every memory transaction against it.

// File: rtl/excl_cache_pkg.sv
// Shared encodings for the exclusive two-level cache controller.
package excl_cache_pkg;

    // Where a request found its line.
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_L1   = 2'd1,
        LVL_L2   = 2'd2,
        LVL_MEM  = 2'd3
    } level_e;

    // Controller sequence: probe, demote victim, optional write-back, fetch, install.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DEMOTE,
        ST_WB,
        ST_FETCH,
        ST_FILL
    } state_e;

endpackage

// File: rtl/excl_victim_pick.sv
// Victim way selector for one set.
// Picks the lowest-numbered invalid way. When all ways are valid it picks the
// way whose age equals WAYS-1 (least recently used).
// Assumes: WAYS is a power of two >= 2 and the ages of a set form a permutation.
module excl_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*WAY_W-1:0] ages,
    output logic [WAY_W-1:0]      way
);

    logic any_free;

    // Free way first (lowest index), otherwise the oldest way.
    always_comb begin
        way      = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                way      = WAY_W'(w);
                any_free = 1'b1;
            end
        end
        if (!any_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (ages[w*WAY_W +: WAY_W] == WAY_W'(WAYS - 1)) way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/excl_tag_store.sv
// Set-associative tag store with valid, dirty and true-LRU age per way.
// Gives one lookup port and one victim port (each with its own set index)
// and one write port. The write port sets valid/dirty/tag of one way and, when
// wr_touch is set, makes that way the most recently used.
// Assumes: SETS and WAYS are powers of two, WAYS >= 2.
module excl_tag_store #(
    parameter int SETS  = 8,
    parameter int WAYS  = 2,
    parameter int TAG_W = 25,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output logic             lk_dirty,
    input  logic [IDX_W-1:0] vc_idx,
    output logic [WAY_W-1:0] vc_way,
    output logic             vc_valid,
    output logic             vc_dirty,
    output logic [TAG_W-1:0] vc_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_touch
);

    logic [WAYS-1:0]       valid_q [SETS];
    logic [WAYS-1:0]       dirty_q [SETS];
    logic [TAG_W-1:0]      tag_q   [SETS][WAYS];
    logic [WAY_W-1:0]      age_q   [SETS][WAYS];
    logic [WAYS-1:0]       hit_vec;
    logic [WAYS*WAY_W-1:0] vc_ages;

    // Compare the probed set against the lookup tag.
    always_comb begin
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hit_vec[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
            if (hit_vec[w]) lk_way = WAY_W'(w);
        end
        lk_hit   = |hit_vec;
        lk_dirty = dirty_q[lk_idx][lk_way];
    end

    // Gather the ages of the victim set for the picker.
    for (genvar g = 0; g < WAYS; g++) begin : g_ages
        assign vc_ages[g*WAY_W +: WAY_W] = age_q[vc_idx][g];
    end

    excl_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid (valid_q[vc_idx]),
        .ages  (vc_ages),
        .way   (vc_way)
    );

    assign vc_valid = valid_q[vc_idx][vc_way];
    assign vc_dirty = dirty_q[vc_idx][vc_way];
    assign vc_tag   = tag_q[vc_idx][vc_way];

    // Valid, dirty and age state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= wr_valid;
            dirty_q[wr_idx][wr_way] <= wr_dirty;
            if (wr_touch) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == wr_way)
                        age_q[wr_idx][w] <= '0;
                    else if (age_q[wr_idx][w] < age_q[wr_idx][wr_way])
                        age_q[wr_idx][w] <= age_q[wr_idx][w] + 1'b1;
                end
            end
        end
    end

    // Tag storage, written only when a line is installed.
    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    // R1: one line never occupies two ways of the same set.
    a_r1_one_way_per_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R6: a valid victim is only chosen when it is the least recently used way.
    a_r6_victim_is_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        vc_valid |-> (vc_ages[vc_way*WAY_W +: WAY_W] == WAY_W'(WAYS - 1)));

endmodule

// File: rtl/excl_l2_swap_ctrl.sv
// Exclusive two-level cache controller (tag/state only).
// Takes one request or invalidate at a time. Sequence for a first-level miss:
// remove the line from the second level if present, demote the first-level
// victim into its own second-level set (writing back a dirty displaced line),
// fetch from memory if needed, then install into the first level.
// Assumes: memory acks each transaction once; line data moves outside this block.
module excl_l2_swap_ctrl
    import excl_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int L1_SETS    = 8,
    parameter int L1_WAYS    = 2,
    parameter int L2_SETS    = 32,
    parameter int L2_WAYS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_level,
    output logic              rsp_inv,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack
);

    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int LINE_W   = ADDR_W - OFF_W;
    localparam int L1_IDX_W = $clog2(L1_SETS);
    localparam int L2_IDX_W = $clog2(L2_SETS);
    localparam int L1_TAG_W = LINE_W - L1_IDX_W;
    localparam int L2_TAG_W = LINE_W - L2_IDX_W;
    localparam int L1_WAY_W = $clog2(L1_WAYS);
    localparam int L2_WAY_W = $clog2(L2_WAYS);

    state_e               state_q, state_d;
    logic [LINE_W-1:0]    line_q, mv_line_q, wb_line_q;
    logic                 write_q, inv_q, miss_q, up_dirty_q;
    logic                 mv_valid_q, mv_dirty_q;
    logic [L1_WAY_W-1:0]  l1_way_q;
    logic [L2_WAY_W-1:0]  l2_way_q;
    logic                 rsp_set;
    level_e               rsp_lvl_d;
    logic                 rsp_valid_q, rsp_inv_q;
    level_e               rsp_level_q;

    // First-level store ports
    logic                 l1_hit, l1_dirty, l1_vc_valid, l1_vc_dirty;
    logic [L1_WAY_W-1:0]  l1_way, l1_vc_way;
    logic [L1_TAG_W-1:0]  l1_vc_tag;
    logic                 l1_wr_en, l1_wr_valid, l1_wr_dirty, l1_wr_touch;
    logic [L1_WAY_W-1:0]  l1_wr_way;

    // Second-level store ports
    logic                 l2_hit, l2_dirty, l2_vc_valid, l2_vc_dirty;
    logic [L2_WAY_W-1:0]  l2_way, l2_vc_way;
    logic [L2_TAG_W-1:0]  l2_vc_tag;
    logic                 l2_wr_en, l2_wr_valid, l2_wr_dirty, l2_wr_touch;
    logic [L2_WAY_W-1:0]  l2_wr_way;
    logic [L2_IDX_W-1:0]  l2_wr_idx;
    logic [L2_TAG_W-1:0]  l2_wr_tag;

    wire [L1_IDX_W-1:0] l1_idx  = line_q[L1_IDX_W-1:0];
    wire [L2_IDX_W-1:0] l2_idx  = line_q[L2_IDX_W-1:0];
    wire [L2_IDX_W-1:0] mv_idx2 = mv_line_q[L2_IDX_W-1:0];

    excl_tag_store #(.SETS(L1_SETS), .WAYS(L1_WAYS), .TAG_W(L1_TAG_W)) u_l1 (
        .clk, .rst_n,
        .lk_idx   (l1_idx),
        .lk_tag   (line_q[LINE_W-1:L1_IDX_W]),
        .lk_hit   (l1_hit),
        .lk_way   (l1_way),
        .lk_dirty (l1_dirty),
        .vc_idx   (l1_idx),
        .vc_way   (l1_vc_way),
        .vc_valid (l1_vc_valid),
        .vc_dirty (l1_vc_dirty),
        .vc_tag   (l1_vc_tag),
        .wr_en    (l1_wr_en),
        .wr_idx   (l1_idx),
        .wr_way   (l1_wr_way),
        .wr_valid (l1_wr_valid),
        .wr_dirty (l1_wr_dirty),
        .wr_tag   (line_q[LINE_W-1:L1_IDX_W]),
        .wr_touch (l1_wr_touch)
    );

    excl_tag_store #(.SETS(L2_SETS), .WAYS(L2_WAYS), .TAG_W(L2_TAG_W)) u_l2 (
        .clk, .rst_n,
        .lk_idx   (l2_idx),
        .lk_tag   (line_q[LINE_W-1:L2_IDX_W]),
        .lk_hit   (l2_hit),
        .lk_way   (l2_way),
        .lk_dirty (l2_dirty),
        .vc_idx   (mv_idx2),
        .vc_way   (l2_vc_way),
        .vc_valid (l2_vc_valid),
        .vc_dirty (l2_vc_dirty),
        .vc_tag   (l2_vc_tag),
        .wr_en    (l2_wr_en),
        .wr_idx   (l2_wr_idx),
        .wr_way   (l2_wr_way),
        .wr_valid (l2_wr_valid),
        .wr_dirty (l2_wr_dirty),
        .wr_tag   (l2_wr_tag),
        .wr_touch (l2_wr_touch)
    );

    // Next state, store write ports and response request.
    always_comb begin
        state_d     = state_q;
        rsp_set     = 1'b0;
        rsp_lvl_d   = LVL_NONE;
        l1_wr_en    = 1'b0;
        l1_wr_way   = l1_way;
        l1_wr_valid = 1'b0;
        l1_wr_dirty = 1'b0;
        l1_wr_touch = 1'b0;
        l2_wr_en    = 1'b0;
        l2_wr_idx   = mv_idx2;
        l2_wr_way   = l2_vc_way;
        l2_wr_valid = 1'b1;
        l2_wr_dirty = mv_dirty_q;
        l2_wr_tag   = mv_line_q[LINE_W-1:L2_IDX_W];
        l2_wr_touch = 1'b1;
        unique case (state_q)
            ST_IDLE: if (inv_valid || req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                // Clear the second-level copy on invalidate or on a swap-up.
                if (l2_hit && (inv_q || !l1_hit)) begin
                    l2_wr_en    = 1'b1;
                    l2_wr_idx   = l2_idx;
                    l2_wr_way   = l2_way;
                    l2_wr_valid = 1'b0;
                    l2_wr_dirty = 1'b0;
                    l2_wr_touch = 1'b0;
                end
                if (inv_q) begin
                    l1_wr_en  = l1_hit;
                    rsp_set   = 1'b1;
                    rsp_lvl_d = l1_hit ? LVL_L1 : (l2_hit ? LVL_L2 : LVL_NONE);
                    state_d   = ST_IDLE;
                end else if (l1_hit) begin
                    l1_wr_en    = 1'b1;
                    l1_wr_valid = 1'b1;
                    l1_wr_dirty = l1_dirty | write_q;
                    l1_wr_touch = 1'b1;
                    rsp_set     = 1'b1;
                    rsp_lvl_d   = LVL_L1;
                    state_d     = ST_IDLE;
                end else begin
                    state_d = ST_DEMOTE;
                end
            end
            ST_DEMOTE: begin
                if (mv_valid_q && l2_vc_valid && l2_vc_dirty) begin
                    state_d = ST_WB;
                end else begin
                    l2_wr_en = mv_valid_q;
                    state_d  = miss_q ? ST_FETCH : ST_FILL;
                end
            end
            ST_WB: if (mem_ack) begin
                l2_wr_en  = 1'b1;
                l2_wr_way = l2_way_q;
                state_d   = miss_q ? ST_FETCH : ST_FILL;
            end
            ST_FETCH: if (mem_ack) state_d = ST_FILL;
            ST_FILL: begin
                l1_wr_en    = 1'b1;
                l1_wr_way   = l1_way_q;
                l1_wr_valid = 1'b1;
                l1_wr_dirty = up_dirty_q | write_q;
                l1_wr_touch = 1'b1;
                rsp_set     = 1'b1;
                rsp_lvl_d   = miss_q ? LVL_MEM : LVL_L2;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequence registers, captured request and victim bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_level_q <= LVL_NONE;
            rsp_inv_q   <= 1'b0;
            line_q      <= '0;
            write_q     <= 1'b0;
            inv_q       <= 1'b0;
            miss_q      <= 1'b0;
            up_dirty_q  <= 1'b0;
            mv_valid_q  <= 1'b0;
            mv_dirty_q  <= 1'b0;
            mv_line_q   <= '0;
            wb_line_q   <= '0;
            l1_way_q    <= '0;
            l2_way_q    <= '0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= rsp_set;
            if (rsp_set) begin
                rsp_level_q <= rsp_lvl_d;
                rsp_inv_q   <= inv_q;
            end
            if (state_q == ST_IDLE) begin
                inv_q   <= inv_valid;
                line_q  <= inv_valid ? inv_addr[ADDR_W-1:OFF_W] : req_addr[ADDR_W-1:OFF_W];
                write_q <= !inv_valid && req_write;
            end
            if (state_q == ST_LOOKUP) begin
                l1_way_q   <= l1_vc_way;
                mv_valid_q <= l1_vc_valid;
                mv_dirty_q <= l1_vc_dirty;
                mv_line_q  <= {l1_vc_tag, l1_idx};
                miss_q     <= !l2_hit;
                up_dirty_q <= l2_hit && l2_dirty;
            end
            if (state_q == ST_DEMOTE) begin
                l2_way_q  <= l2_vc_way;
                wb_line_q <= {l2_vc_tag, mv_idx2};
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_level = rsp_level_q;
    assign rsp_inv   = rsp_inv_q;
    assign mem_req   = (state_q == ST_WB) || (state_q == ST_FETCH);
    assign mem_we    = (state_q == ST_WB);
    assign mem_addr  = {(state_q == ST_WB) ? wb_line_q : line_q, {OFF_W{1'b0}}};

    // R1: the probed line is never found in both levels.
    a_r1_not_in_both: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> !(l1_hit && l2_hit));

    // R2: a first-level hit answers straight from the probe cycle.
    a_r2_l1_hit_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_inv && rsp_level == LVL_L1) |-> ($past(state_q) == ST_LOOKUP));

    // R9: the response is a single-cycle pulse.
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: a pending memory transaction holds until acknowledged.
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a write-back only ever targets a line that is not being requested.
    a_r5_wb_other_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[ADDR_W-1:OFF_W] != line_q));

endmodule

// File: tb/test_excl_l2_swap_ctrl.sv
module test_excl_l2_swap_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, inv_valid = 1'b0, mem_ack = 1'b0;
    logic [31:0] req_addr = '0, inv_addr = '0;
    logic        req_ready, rsp_valid, rsp_inv, mem_req, mem_we;
    logic [1:0]  rsp_level;
    logic [31:0] mem_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;  // 50 MHz

    excl_l2_swap_ctrl i_excl_l2_swap_ctrl (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write,
        .inv_valid, .inv_addr, .rsp_valid, .rsp_level, .rsp_inv,
        .mem_req, .mem_we, .mem_addr, .mem_ack
    );

    // Reference state of both levels, kept by line address.
    logic [27:0] m1_line [8][2];
    bit          m1_v    [8][2];
    bit          m1_d    [8][2];
    int          m1_age  [8][2];
    logic [27:0] m2_line [32][4];
    bit          m2_v    [32][4];
    bit          m2_d    [32][4];
    int          m2_age  [32][4];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 2; w++) begin m1_v[s][w] = 0; m1_d[s][w] = 0; m1_age[s][w] = w; end
        for (int s = 0; s < 32; s++)
            for (int w = 0; w < 4; w++) begin m2_v[s][w] = 0; m2_d[s][w] = 0; m2_age[s][w] = w; end
    endtask

    function automatic int pick1(input int s);
        for (int w = 0; w < 2; w++) if (!m1_v[s][w]) return w;
        for (int w = 0; w < 2; w++) if (m1_age[s][w] == 1) return w;
        return 0;
    endfunction

    function automatic int pick2(input int s);
        for (int w = 0; w < 4; w++) if (!m2_v[s][w]) return w;
        for (int w = 0; w < 4; w++) if (m2_age[s][w] == 3) return w;
        return 0;
    endfunction

    task automatic touch1(input int s, input int w);
        int a = m1_age[s][w];
        for (int x = 0; x < 2; x++)
            if (x == w) m1_age[s][x] = 0; else if (m1_age[s][x] < a) m1_age[s][x]++;
    endtask

    task automatic touch2(input int s, input int w);
        int a = m2_age[s][w];
        for (int x = 0; x < 4; x++)
            if (x == w) m2_age[s][x] = 0; else if (m2_age[s][x] < a) m2_age[s][x]++;
    endtask

    // Apply one operation to the reference; report expected level and write-back.
    task automatic model_op(input logic [31:0] addr, input bit wr, input bit inv,
                            output int lvl, output bit wb, output logic [27:0] wb_line);
        logic [27:0] line = addr[31:4];
        int s1 = int'(line[2:0]);
        int s2 = int'(line[4:0]);
        int h1 = -1, h2 = -1;
        bit dup = 0;
        wb = 0; wb_line = '0;
        for (int w = 0; w < 2; w++) if (m1_v[s1][w] && m1_line[s1][w] == line) h1 = w;
        for (int w = 0; w < 4; w++) if (m2_v[s2][w] && m2_line[s2][w] == line) h2 = w;
        if (inv) begin
            if (h1 >= 0) begin m1_v[s1][h1] = 0; m1_d[s1][h1] = 0; lvl = 1; end
            else if (h2 >= 0) begin m2_v[s2][h2] = 0; m2_d[s2][h2] = 0; lvl = 2; end
            else lvl = 0;
            return;
        end
        if (h1 >= 0) begin
            m1_d[s1][h1] |= wr; touch1(s1, h1); lvl = 1; return;
        end
        if (h2 >= 0) begin
            dup = m2_d[s2][h2]; m2_v[s2][h2] = 0; m2_d[s2][h2] = 0;
        end
        begin
            int v1 = pick1(s1);
            if (m1_v[s1][v1]) begin
                logic [27:0] mv = m1_line[s1][v1];
                int sv = int'(mv[4:0]);
                int w2 = pick2(sv);
                if (m2_v[sv][w2] && m2_d[sv][w2]) begin wb = 1; wb_line = m2_line[sv][w2]; end
                m2_line[sv][w2] = mv; m2_v[sv][w2] = 1; m2_d[sv][w2] = m1_d[s1][v1]; touch2(sv, w2);
            end
            m1_line[s1][v1] = line; m1_v[s1][v1] = 1; m1_d[s1][v1] = dup | wr; touch1(s1, v1);
        end
        lvl = (h2 >= 0) ? 2 : 3;
    endtask

    int wb_total = 0;

    // Drive one operation, serve memory, compare the outcome with the reference.
    task automatic do_op(input logic [31:0] addr, input bit wr, input bit inv,
                         input string tag, input bit with_req = 0,
                         input logic [31:0] other = '0);
        int lvl, waited = 0, n_rd = 0, n_wb = 0;
        bit wb, seen = 0, busy_bad = 0, hung = 0, got_inv = 0;
        logic [27:0] wb_line;
        logic [31:0] rd_a = '0, wb_a = '0;
        logic [1:0] got_lvl = '0;
        model_op(addr, wr, inv, lvl, wb, wb_line);
        @(negedge clk);
        check(req_ready === 1'b1, "R9", "ready when idle", {31'd0, req_ready}, 1);
        if (inv) begin
            inv_valid = 1; inv_addr = addr;
            req_valid = with_req; req_addr = other; req_write = 1;
        end else begin
            req_valid = 1; req_addr = addr; req_write = wr;
        end
        @(negedge clk);
        inv_valid = 0; req_valid = 0; req_write = 0;
        while (!seen && !hung) begin
            @(negedge clk);
            waited++;
            if (waited > 500) hung = 1;
            else if (mem_ack) mem_ack = 0;
            else if (rsp_valid) begin seen = 1; got_lvl = rsp_level; got_inv = rsp_inv; end
            else begin
                if (req_ready) busy_bad = 1;
                if (mem_req) begin
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    if (mem_we) begin n_wb++; wb_a = mem_addr; end
                    else begin n_rd++; rd_a = mem_addr; end
                    mem_ack = 1;
                end
            end
        end
        mem_ack = 0;
        if (hung) begin
            check(0, tag, "watchdog expired", 0, 1);
            return;
        end
        check(!busy_bad, "R9", "ready low while busy", {31'd0, busy_bad}, 0);
        check(got_inv == inv, inv ? "R8" : tag, "response kind", {31'd0, got_inv}, {31'd0, inv});
        check(int'(got_lvl) == lvl, tag, "response level", {30'd0, got_lvl}, lvl);
        check(n_rd == (lvl == 3 && !inv ? 1 : 0), "R4", "memory reads", n_rd, (lvl == 3 && !inv) ? 1 : 0);
        if (n_rd == 1 && lvl == 3)
            check(rd_a == {addr[31:4], 4'h0}, "R4", "read address", rd_a, {addr[31:4], 4'h0});
        check(n_wb == int'(wb), "R5", "write-back count (R7 dirty tracking)", n_wb, {31'd0, wb});
        if (wb && n_wb == 1)
            check(wb_a == {wb_line, 4'h0}, "R5", "write-back address", wb_a, {wb_line, 4'h0});
        wb_total += n_wb;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9", "response pulse length", {31'd0, rsp_valid}, 0);
    endtask

    initial begin
        model_reset();
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state at the ports
        check(req_ready === 1'b1, "R10", "req_ready after reset", {31'd0, req_ready}, 1);
        check(rsp_valid === 1'b0, "R10", "rsp_valid after reset", {31'd0, rsp_valid}, 0);
        check(mem_req === 1'b0, "R10", "mem_req after reset", {31'd0, mem_req}, 0);

        // R10 / R4: first access misses; R2: repeats hit the first level
        do_op(32'h0000_1000, 0, 0, "R10");
        do_op(32'h0000_1008, 0, 0, "R2");
        do_op(32'h0000_1004, 1, 0, "R2");
        // R6: same first-level set, LRU victim demoted
        do_op(32'h0000_2000, 0, 0, "R4");
        do_op(32'h0000_3000, 0, 0, "R6");
        // R3: swap-up of the demoted dirty line, R1: now answers from level 1
        do_op(32'h0000_1000, 0, 0, "R3");
        do_op(32'h0000_1000, 0, 0, "R1");
        do_op(32'h0000_2000, 0, 0, "R3");
        // R8: invalidate in each level and a miss
        do_op(32'h0000_1000, 0, 1, "R8");
        do_op(32'h0000_1000, 0, 0, "R8");
        do_op(32'h0000_3000, 0, 1, "R8");
        do_op(32'h0000_3000, 0, 1, "R8");
        // R5 / R7: dirty lines sharing one set in both levels force write-backs
        for (int k = 0; k < 8; k++) do_op(32'h0001_0000 + k * 32'h200, 1, 0, "R5");
        check(wb_total > 0, "R5", "dirty eviction reached memory", wb_total, 1);
        // R5: clean lines through the same set
        for (int k = 0; k < 8; k++) do_op(32'h0004_0000 + k * 32'h200, 0, 0, "R6");
        // R8: invalidate wins over a simultaneous request
        do_op(32'h0001_0000, 0, 1, "R8", 1, 32'h0007_7000);
        do_op(32'h0007_7000, 0, 0, "R8");

        // Random mix over a small conflicting pool
        for (int i = 0; i < 700; i++) begin
            logic [31:0] a = ($urandom_range(0, 3) << 16) | ($urandom_range(0, 63) << 4) | $urandom_range(0, 15);
            int r = $urandom_range(0, 99);
            do_op(a, r < 30, r >= 90, "R6");
        end

        // R1: each line lives in one place, so a second invalidate finds nothing
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a = ($urandom_range(0, 3) << 16) | ($urandom_range(0, 63) << 4);
            do_op(a, 0, 1, "R1");
            do_op(a, 0, 1, "R1");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule